// File: doc/BRIEF.md
# SMBus Clock Configuration Register Slave

This block is the serial control port of a multi-output clock generator. It samples a two-wire bus with the system clock and decodes one slave address pair: the even address takes block writes and the odd one takes block reads. It owns ten configuration bytes. Their contents drive the clock-generator logic through a flat parallel output. A few bit positions are not stored at all; they reflect input pins or a gated combination of a pin and a stored bit.

A write carries the address, a command byte, a byte-count byte and then data bytes. The command value and the count value are acknowledged and otherwise ignored. The data always fills the registers in order from index 0. A read returns a count byte of 10 and then the registers from index 0 onward, until the master answers a byte with no acknowledge. The data line is only ever pulled low and is never driven high.

Top module: `smbus_cfg_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read). Any other address byte gets no acknowledge, and the bytes that follow it, up to the next START, are neither acknowledged nor stored.
- R2: In a write, the first two bytes after the address are the command and the count. Both are acknowledged, and neither value changes which register the data goes to.
- R3: In a write, every data byte is acknowledged. The data bytes are stored at register indices 0, 1, 2 and so on, in the order they arrive.
- R4: Some byte-0 and byte-1 bits read the pins live. Byte 0 bits 2..0 return freqSel[2..0] and byte 0 bit 4 returns cpuHaltN. Byte 1 bit 7 returns curMult. A write to any of these positions has no effect.
- R5: Byte 0 bit 3 reads as the stored bit ANDed with pciHaltN. It reads 0 whenever either of the two is 0, and the stored bit is kept while the pin is low.
- R6: Byte 6 always reads 0x13. A write to it is acknowledged and discarded.
- R7: After reset the register bytes are as follows. Byte 0 has bits 7..5 = 0 and a stored bit 3 = 1. Byte 1 has bits 6..3 = 0 and bits 2..0 = 1. Bytes 2, 3, 4 and 5 are 0x7F, 0xC7, 0x3F and 0x40. Bytes 7, 8 and 9 are 0x00.
- R8: cfgFlat[8i+7:8i] carries byte i exactly as a read would return it. Bytes 2, 3, 4, 5, 7, 8 and 9 are fully writable, including the divider-source select in bit 0 of byte 9. Byte 0 bits 7..5 and 3 and byte 1 bits 6..0 are writable. The values persist across transactions until reset.
- R9: A read returns the count byte 10, then bytes 0..9, then 0x00 for any index beyond 9. The master ends the read by not acknowledging a byte, and the slave then releases SDA. In a write, data bytes beyond index 9 are acknowledged and discarded.
- R10: A STOP inside a byte abandons the transfer without storing anything. A START at any point, including a repeated START, begins a fresh address phase. sdaDrvLow changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low power-up reset |
| sclIn | input | 1 | Bus clock line |
| sdaIn | input | 1 | Bus data line as seen on the wire |
| sdaDrvLow | output | 1 | 1 pulls the data line low, 0 releases it |
| freqSel | input | 3 | Frequency-select pins, read back in byte 0 bits 2..0 |
| cpuHaltN | input | 1 | CPU clock stop pin, read back in byte 0 bit 4 |
| pciHaltN | input | 1 | PCI clock stop pin, ANDed into byte 0 bit 3 |
| curMult | input | 1 | Output-current multiplier pin, read back in byte 1 bit 7 |
| cfgFlat | output | 80 | All ten register bytes, byte i at bits 8i+7..8i |

## Verification
Three full ten-byte images are written and then read back. Each uses a different command value and includes all-ones and all-zeros bytes in the positions where read-only and gated bits sit. This separates the stored bits from the pin-driven bits and shows whether the command byte leaks into the register index. Changing the pin levels between reads separates live read-back from stored copies, and it exposes the AND on the PCI stop bit from both sides. The directed cases cover these boundaries:
- a foreign address on both the write and the read side;
- extra bytes written and read beyond index 9;
- a STOP four bits into a data byte;
- a repeated START that turns a write into a read;
- a reset after programming, which must bring back the default image.

// File: rtl/smbus_cfg_pkg.sv
package smbus_cfg_pkg;
  localparam int REG_COUNT = 10;
  localparam int IDX_W = 4;
  localparam logic [7:0] SIGNATURE = 8'h13;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACKOUT, ST_TX, ST_ACKIN} busState_t;

  // Strobes and index from the bus control to the register datapath.
  typedef struct packed {
    logic             wrStb;
    logic [IDX_W-1:0] wrIdx;
    logic [7:0]       wrData;
    logic [IDX_W-1:0] rdIdx;
  } regCmd_t;

  function automatic logic [7:0] regDefault(int idx);
    case (idx)
      0:       return 8'h08;
      1:       return 8'h07;
      2:       return 8'h7F;
      3:       return 8'hC7;
      4:       return 8'h3F;
      5:       return 8'h40;
      6:       return SIGNATURE;
      default: return 8'h00;
    endcase
  endfunction

  // Bits a bus write may change in each byte.
  function automatic logic [7:0] regWrMask(int idx);
    case (idx)
      0:       return 8'hE8;
      1:       return 8'h7F;
      6:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/smbus_cfg_ctrl.sv
module smbus_cfg_ctrl
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] rdByte,
  output regCmd_t    regCmd,
  output logic       sdaDrvLow
);
  localparam logic [1:0] HDR_DATA = 2'd3;
  localparam logic [7:0] REPLY_COUNT = 8'(REG_COUNT);

  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  logic sclRise, sclFall, startCond, stopCond;
  assign sclRise   = sclSync[1] & ~sclPrev;
  assign sclFall   = ~sclSync[1] & sclPrev;
  assign startCond = sclSync[1] & sclPrev & sdaPrev & ~sdaSync[1];
  assign stopCond  = sclSync[1] & sclPrev & ~sdaPrev & sdaSync[1];

  busState_t stateQ;
  logic [3:0] bitCntQ;
  logic [7:0] shiftQ, txShQ, wrDataQ;
  logic [1:0] hdrQ;
  logic isRdQ, firstTxQ, ackSeenQ, drvQ, wrStbQ;
  logic [IDX_W-1:0] dataIdxQ, wrIdxQ, idxNext;
  logic [7:0] txByte;

  assign idxNext = (dataIdxQ == '1) ? dataIdxQ : dataIdxQ + 1'b1;
  assign txByte  = firstTxQ ? REPLY_COUNT : rdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      bitCntQ  <= '0;
      shiftQ   <= '0;
      txShQ    <= '0;
      hdrQ     <= '0;
      isRdQ    <= 1'b0;
      firstTxQ <= 1'b0;
      ackSeenQ <= 1'b0;
      drvQ     <= 1'b0;
      dataIdxQ <= '0;
      wrStbQ   <= 1'b0;
      wrIdxQ   <= '0;
      wrDataQ  <= '0;
    end else begin
      wrStbQ <= 1'b0;
      if (startCond) begin
        stateQ   <= ST_RX;
        bitCntQ  <= '0;
        hdrQ     <= '0;
        dataIdxQ <= '0;
        drvQ     <= 1'b0;
      end else if (stopCond) begin
        stateQ <= ST_IDLE;
        drvQ   <= 1'b0;
      end else begin
        case (stateQ)
          ST_RX: begin
            if (sclRise && bitCntQ < 4'd8) begin
              shiftQ  <= {shiftQ[6:0], sdaSync[1]};
              bitCntQ <= bitCntQ + 1'b1;
            end else if (sclFall && bitCntQ == 4'd8) begin
              if (hdrQ == 2'd0) begin
                if (shiftQ[7:1] == SLAVE_ADDR) begin
                  drvQ     <= 1'b1;
                  isRdQ    <= shiftQ[0];
                  firstTxQ <= 1'b1;
                  hdrQ     <= 2'd1;
                  stateQ   <= ST_ACKOUT;
                end else begin
                  stateQ <= ST_IDLE;
                end
              end else begin
                drvQ   <= 1'b1;
                stateQ <= ST_ACKOUT;
                if (hdrQ != HDR_DATA) begin
                  hdrQ <= hdrQ + 1'b1;
                end else begin
                  wrStbQ   <= 1'b1;
                  wrIdxQ   <= dataIdxQ;
                  wrDataQ  <= shiftQ;
                  dataIdxQ <= idxNext;
                end
              end
            end
          end
          ST_ACKOUT: begin
            if (sclFall) begin
              if (isRdQ) begin
                drvQ     <= ~txByte[7];
                txShQ    <= {txByte[6:0], 1'b0};
                bitCntQ  <= 4'd1;
                stateQ   <= ST_TX;
                firstTxQ <= 1'b0;
                if (!firstTxQ) dataIdxQ <= idxNext;
              end else begin
                drvQ    <= 1'b0;
                bitCntQ <= '0;
                stateQ  <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCntQ == 4'd8) begin
                drvQ   <= 1'b0;
                stateQ <= ST_ACKIN;
              end else begin
                drvQ    <= ~txShQ[7];
                txShQ   <= {txShQ[6:0], 1'b0};
                bitCntQ <= bitCntQ + 1'b1;
              end
            end
          end
          ST_ACKIN: begin
            if (sclRise) ackSeenQ <= ~sdaSync[1];
            if (sclFall) begin
              if (ackSeenQ) begin
                drvQ     <= ~txByte[7];
                txShQ    <= {txByte[6:0], 1'b0};
                bitCntQ  <= 4'd1;
                stateQ   <= ST_TX;
                firstTxQ <= 1'b0;
                if (!firstTxQ) dataIdxQ <= idxNext;
              end else begin
                drvQ   <= 1'b0;
                stateQ <= ST_IDLE;
              end
            end
          end
          default: drvQ <= 1'b0;
        endcase
      end
    end
  end

  always_comb begin
    regCmd.wrStb  = wrStbQ;
    regCmd.wrIdx  = wrIdxQ;
    regCmd.wrData = wrDataQ;
    regCmd.rdIdx  = dataIdxQ;
  end

  assign sdaDrvLow = drvQ;
endmodule

// File: rtl/smbus_cfg_regs.sv
module smbus_cfg_regs
  import smbus_cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  regCmd_t                  regCmd,
  input  logic [2:0]               freqSel,
  input  logic                     cpuHaltN,
  input  logic                     pciHaltN,
  input  logic                     curMult,
  output logic [7:0]               rdByte,
  output logic [8*REG_COUNT-1:0]   viewFlat
);
  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    localparam logic [7:0] MASK = regWrMask(i);
    logic [7:0] regQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regQ <= regDefault(i);
      else if (regCmd.wrStb && regCmd.wrIdx == IDX_W'(i))
        regQ <= (regQ & ~MASK) | (regCmd.wrData & MASK);
    end

    if (i == 0) begin : g_live0
      assign viewFlat[8*i +: 8] = (regQ & 8'hE0) |
                                  {3'b000, cpuHaltN, regQ[3] & pciHaltN, freqSel};
    end else if (i == 1) begin : g_live1
      assign viewFlat[8*i +: 8] = {curMult, 7'b0} | (regQ & 8'h7F);
    end else begin : g_plain
      assign viewFlat[8*i +: 8] = regQ;
    end
  end

  always_comb begin
    rdByte = 8'h00;
    for (int i = 0; i < REG_COUNT; i++)
      if (regCmd.rdIdx == IDX_W'(i)) rdByte = viewFlat[8*i +: 8];
  end
endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import smbus_cfg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaDrvLow,
  input  logic [2:0]             freqSel,
  input  logic                   cpuHaltN,
  input  logic                   pciHaltN,
  input  logic                   curMult,
  output logic [8*REG_COUNT-1:0] cfgFlat
);
  regCmd_t regCmd;
  logic [7:0] rdByte;

  smbus_cfg_ctrl #(.SLAVE_ADDR(SLAVE_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdByte(rdByte), .regCmd(regCmd), .sdaDrvLow(sdaDrvLow)
  );

  smbus_cfg_regs u_regs (
    .clk(clk), .rstN(rstN), .regCmd(regCmd),
    .freqSel(freqSel), .cpuHaltN(cpuHaltN), .pciHaltN(pciHaltN), .curMult(curMult),
    .rdByte(rdByte), .viewFlat(cfgFlat)
  );
endmodule

// File: rtl/smbus_cfg_slave_chk.sv
module smbus_cfg_slave_chk
  import smbus_cfg_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic                   sclIn,
  input logic                   sdaDrvLow,
  input logic [2:0]             freqSel,
  input logic                   cpuHaltN,
  input logic                   pciHaltN,
  input logic                   curMult,
  input logic [8*REG_COUNT-1:0] cfgFlat
);
  // R10: the data line drive moves only while the clock line is low
  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrvLow != $past(sdaDrvLow)) |-> !sclIn);

  // R3: stored bytes are updated only in a clock-low window after a byte
  a_r3_write_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFlat[79:16] != $past(cfgFlat[79:16])) |-> !sclIn);

  // R4: live pin read-back positions
  a_r4_live_pins: assert property (@(posedge clk) disable iff (!rstN)
    (cfgFlat[2:0] == freqSel) && (cfgFlat[4] == cpuHaltN) && (cfgFlat[15] == curMult));

  // R5: a low PCI stop pin forces the gated bit low
  a_r5_pci_and: assert property (@(posedge clk) disable iff (!rstN)
    !pciHaltN |-> !cfgFlat[3]);

  // R6: the signature byte never moves
  a_r6_signature: assert property (@(posedge clk) disable iff (!rstN)
    cfgFlat[55:48] == SIGNATURE);
endmodule

bind smbus_cfg_slave smbus_cfg_slave_chk u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
  .freqSel(freqSel), .cpuHaltN(cpuHaltN), .pciHaltN(pciHaltN),
  .curMult(curMult), .cfgFlat(cfgFlat)
);

// File: tb/tb_smbus_cfg_slave.sv
`timescale 1ns/1ps
module tb_smbus_cfg_slave;
  localparam int QTR = 10;

  logic clk = 1'b0;
  logic rstN;
  logic mScl, mSda;
  logic sdaLine;
  logic sdaDrvLow;
  logic [2:0] freqSel;
  logic cpuHaltN, pciHaltN, curMult;
  logic [79:0] cfgFlat;

  always #2.5 clk = ~clk;
  assign sdaLine = mSda & ~sdaDrvLow;

  smbus_cfg_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .sdaDrvLow(sdaDrvLow),
    .freqSel(freqSel), .cpuHaltN(cpuHaltN), .pciHaltN(pciHaltN), .curMult(curMult),
    .cfgFlat(cfgFlat)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // cmd byte then bytes 0..9
  localparam logic [7:0] VEC [3][11] = '{
    '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF},
    '{8'h5A, 8'h00, 8'h00, 8'hAA, 8'h55, 8'h0F, 8'hF0, 8'h00, 8'h5C, 8'h3E, 8'h01},
    '{8'hFF, 8'hA8, 8'h93, 8'h7F, 8'hC7, 8'h3F, 8'h40, 8'h21, 8'h00, 8'h81, 8'h80}
  };

  logic [7:0] mReg [10];
  logic [7:0] wrBuf [16];
  logic [7:0] rdBuf [16];

  task automatic modelReset();
    mReg[0] = 8'h08; mReg[1] = 8'h07; mReg[2] = 8'h7F; mReg[3] = 8'hC7;
    mReg[4] = 8'h3F; mReg[5] = 8'h40; mReg[6] = 8'h13;
    mReg[7] = 8'h00; mReg[8] = 8'h00; mReg[9] = 8'h00;
  endtask

  task automatic modelWrite(int i, logic [7:0] w);
    if (i == 0) mReg[0] = (mReg[0] & 8'h17) | (w & 8'hE8);
    else if (i == 1) mReg[1] = (mReg[1] & 8'h80) | (w & 8'h7F);
    else if (i != 6 && i < 10) mReg[i] = w;
  endtask

  function automatic logic [7:0] viewB(int i);
    if (i == 0) return {mReg[0][7:5], cpuHaltN, mReg[0][3] & pciHaltN, freqSel};
    if (i == 1) return {curMult, mReg[1][6:0]};
    if (i == 6) return 8'h13;
    if (i >= 10) return 8'h00;
    return mReg[i];
  endfunction

  function automatic logic [79:0] cfgExp();
    logic [79:0] v;
    for (int i = 0; i < 10; i++) v[8*i +: 8] = viewB(i);
    return v;
  endfunction

  task automatic chk(string req, logic [79:0] act, logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitQ(int n = 1);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b0; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic busStop();
    mSda = 1'b0; waitQ();
    mScl = 1'b1; waitQ();
    mSda = 1'b1; waitQ(2);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      mSda = b[i]; waitQ();
      mScl = 1'b1; waitQ(2);
      mScl = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(logic [7:0] b, output logic ack);
    sendBits(b, 8);
    mSda = 1'b1; waitQ();
    mScl = 1'b1; waitQ();
    ack = ~sdaLine; waitQ();
    mScl = 1'b0; waitQ();
  endtask

  task automatic recvByte(logic giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ();
      mScl = 1'b1; waitQ();
      b[i] = sdaLine; waitQ();
      mScl = 1'b0;
    end
    mSda = giveAck ? 1'b0 : 1'b1; waitQ();
    mScl = 1'b1; waitQ(2);
    mScl = 1'b0; waitQ();
    mSda = 1'b1;
  endtask

  task automatic wrTxn(logic [7:0] addr, logic [7:0] cmd, int n,
                       output logic addrAck, output logic allAck);
    logic a;
    busStart();
    sendByte(addr, addrAck);
    allAck = 1'b1;
    sendByte(cmd, a); allAck &= a;
    sendByte(8'(n), a); allAck &= a;
    for (int i = 0; i < n; i++) begin
      sendByte(wrBuf[i], a); allAck &= a;
    end
    busStop();
  endtask

  task automatic rdTxn(int n, output logic addrAck, output logic [7:0] cnt);
    busStart();
    sendByte(8'hD3, addrAck);
    cnt = 8'h00;
    if (addrAck) begin
      recvByte(1'b1, cnt);
      for (int i = 0; i < n; i++) recvByte(i != n - 1, rdBuf[i]);
    end
    busStop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic aA, dA;
    logic [7:0] cnt;
    rstN = 1'b0; mScl = 1'b1; mSda = 1'b1;
    freqSel = 3'b010; cpuHaltN = 1'b1; pciHaltN = 1'b1; curMult = 1'b0;
    modelReset();
    repeat (20) @(negedge clk);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // R7 reset image and released line
    chk("R7 reset image", cfgFlat, cfgExp());
    chk("R7 line released", 80'(sdaDrvLow), 80'h0);

    // table walk: write 12 data bytes, read 12 back
    for (int v = 0; v < 3; v++) begin
      for (int i = 0; i < 10; i++) wrBuf[i] = VEC[v][i+1];
      wrBuf[10] = 8'hFF; wrBuf[11] = 8'hA5;
      wrTxn(8'hD2, VEC[v][0], 12, aA, dA);
      for (int i = 0; i < 12; i++) modelWrite(i, wrBuf[i]);
      chk("R1 write address ack", 80'(aA), 80'h1);
      chk("R2 R3 R9 all header and data bytes acked", 80'(dA), 80'h1);
      chk("R8 R2 cfg output after write", cfgFlat, cfgExp());
      freqSel = 3'(v * 3 + 1); cpuHaltN = v[0]; curMult = ~v[0];
      repeat (4) @(negedge clk);
      rdTxn(12, aA, cnt);
      chk("R1 read address ack", 80'(aA), 80'h1);
      chk("R9 count byte", 80'(cnt), 80'd10);
      for (int i = 0; i < 10; i++)
        chk($sformatf("R3 R4 R6 read byte %0d", i), 80'(rdBuf[i]), 80'(viewB(i)));
      chk("R9 beyond index 9 reads zero", {64'h0, rdBuf[10], rdBuf[11]}, 80'h0);
      chk("R9 SDA released after nack", 80'(sdaDrvLow), 80'h0);
    end

    // R4 R5: live pins and gated bit; last stored byte 0 bit 3 is 1
    freqSel = 3'b101; cpuHaltN = 1'b0; pciHaltN = 1'b0; curMult = 1'b1;
    repeat (4) @(negedge clk);
    rdTxn(2, aA, cnt);
    chk("R5 gated bit low with pin low", 80'(rdBuf[0][3]), 80'h0);
    chk("R4 live bits byte 0", 80'(rdBuf[0]), 80'(viewB(0)));
    chk("R4 live bit byte 1", 80'(rdBuf[1]), 80'(viewB(1)));
    pciHaltN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R5 stored bit kept through pin low", 80'(cfgFlat[3]), 80'h1);

    // R1 foreign addresses
    wrBuf[0] = 8'h00; wrBuf[1] = 8'h00;
    wrTxn(8'hD4, 8'h00, 2, aA, dA);
    chk("R1 foreign write address nacked", 80'(aA), 80'h0);
    chk("R1 bytes after foreign address nacked", 80'(dA), 80'h0);
    chk("R1 foreign write stores nothing", cfgFlat, cfgExp());
    busStart();
    sendByte(8'hD5, aA);
    busStop();
    chk("R1 foreign read address nacked", 80'(aA), 80'h0);

    // R10 STOP inside a data byte
    busStart();
    sendByte(8'hD2, aA);
    sendByte(8'h00, dA);
    sendByte(8'h01, dA);
    sendBits(8'h00, 4);
    busStop();
    chk("R10 aborted byte not stored", cfgFlat, cfgExp());
    wrBuf[0] = 8'h20;
    wrTxn(8'hD2, 8'h77, 1, aA, dA);
    modelWrite(0, 8'h20);
    chk("R10 next transfer acked after abort", 80'(aA & dA), 80'h1);
    chk("R10 R3 write after abort stored", cfgFlat, cfgExp());

    // R10 repeated START turns a write into a read
    busStart();
    sendByte(8'hD2, aA);
    sendByte(8'h33, dA);
    busStart();
    sendByte(8'hD3, aA);
    recvByte(1'b1, cnt);
    recvByte(1'b0, rdBuf[0]);
    busStop();
    chk("R10 repeated START read acked", 80'(aA), 80'h1);
    chk("R10 repeated START count", 80'(cnt), 80'd10);
    chk("R10 repeated START byte 0", 80'(rdBuf[0]), 80'(viewB(0)));

    // R7 reset restores defaults after programming
    rstN = 1'b0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    modelReset();
    repeat (5) @(negedge clk);
    chk("R7 defaults after second reset", cfgFlat, cfgExp());

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule